// File: doc/BRIEF.md
# Selectable SONET Clock Divider Chain

This block takes one fast clock, typically a 622.08 MHz oscillator output, and derives two slower clocks from it. One is a line clock at exactly one quarter of the input rate. The other is a regenerated copy of the reference clock. Its division ratio of 8, 12 or 16 is chosen by two select pins, so the same chain serves reference inputs of 77.76, 51.84 or 38.88 MHz. The block also emits a single-cycle feedback pulse once per reference period, which a phase detector outside the block can compare against the incoming reference.

The ratio is built as a fixed divide-by-4 prescaler followed by a post-divider that counts 2, 3 or 4 prescaler periods. Both stages run on the fast clock, and the regenerated reference is taken from a flop, so it has an exact 50% duty cycle at every ratio. A new ratio is picked up only when a full output period ends. A disable input silences the reference output without stopping the counters, so the output comes back in its old phase when it is enabled again. If both select pins are high, the slowest ratio wins and a sticky configuration error flag is raised.

Top module: `sonet_clk_divider`

## Requirements
- R1: `clk_quarter` has a period of 4 fast cycles and is high for 2 of them.
- R2: With `sel_div16` high, `clk_ref_out` has a period of 16 fast cycles and is high for 8 of them.
- R3: With both select pins low, `clk_ref_out` has a period of 12 fast cycles and is high for 6 of them.
- R4: With `sel_div8` high and `sel_div16` low, `clk_ref_out` has a period of 8 fast cycles and is high for 4 of them.
- R5: While `rst` is high, `clk_quarter`, `clk_ref_out`, `fb_pulse` and `cfg_err` are all low. After reset is released, `fb_pulse` is high in the first cycle. When the output is enabled, `clk_ref_out` rises at the second edge.
- R6: `fb_pulse` is high for exactly one fast cycle per selected output period. `clk_ref_out` only rises on the edge that ends a cycle in which `fb_pulse` was high.
- R7: From the first edge that samples `ref_disable` high, `clk_ref_out` stays low. The dividers keep running meanwhile, so `fb_pulse` continues once per period.
- R8: After `ref_disable` returns low, `clk_ref_out` resumes at a period boundary. Each rise comes one fast cycle before a rising edge of `clk_quarter`, and the period is unchanged.
- R9: A change of the select pins lets the current output period finish at the old ratio. The new ratio applies from the next period on.
- R10: With both select pins high, the ratio is 16 and `cfg_err` goes high on the next edge. It stays high until `rst`, even after the pins return to a legal setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock driving both dividers |
| rst | input | 1 | Synchronous active-high reset of all dividers and flags |
| sel_div16 | input | 1 | Selects the ratio-16 reference (priority select) |
| sel_div8 | input | 1 | Selects the ratio-8 reference |
| ref_disable | input | 1 | High forces the regenerated reference output low |
| clk_quarter | output | 1 | Fast clock divided by 4, 50% duty |
| clk_ref_out | output | 1 | Regenerated reference clock, ratio 8/12/16, 50% duty |
| fb_pulse | output | 1 | One-cycle pulse at the start of each reference period |
| cfg_err | output | 1 | Sticky flag: both select pins were seen high |

## Verification
The assertions assume that all inputs change synchronously to `clk_fast` and that `rst` is held high for at least one edge before the first checked cycle. They also assume the feedback pulse is never wanted back to back, which holds because the smallest post-divider ratio is 2. The bench drives every input on the falling edge, asserts reset from time zero, and changes select pins only mid-period, a few cycles after an observed rising edge. This keeps the period in which the change happens unambiguous.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      RSEL_FAST = 2'd0,
      RSEL_MID  = 2'd1,
      RSEL_SLOW = 2'd2
   } rsel_e;

   // the slow-ratio select has priority over the fast-ratio select
   function automatic rsel_e decode_sel(input logic s_slow, input logic s_fast);
      if (s_slow)
         return RSEL_SLOW;
      else if (s_fast)
         return RSEL_FAST;
      return RSEL_MID;
   endfunction

endpackage

// File: rtl/sdiv_prescale.sv
module sdiv_prescale #(
   parameter int PRE_DIV = 4,
   localparam int QW     = $clog2(PRE_DIV),
   localparam int HALF   = PRE_DIV / 2
) (
   input  logic          clk,
   input  logic          rst,
   output logic [QW-1:0] q_cnt,
   output logic          q_wrap,
   output logic          quarter
);

   logic [QW-1:0] q_next;

   assign q_wrap = (q_cnt == QW'(PRE_DIV - 1));
   assign q_next = q_wrap ? '0 : q_cnt + QW'(1);

   // reset parks the counter on its last count so the first edge starts a period
   always_ff @(posedge clk) begin
      if (rst) begin
         q_cnt   <= QW'(PRE_DIV - 1);
         quarter <= 1'b0;
      end else begin
         q_cnt   <= q_next;
         quarter <= (q_next >= QW'(HALF));
      end
   end

endmodule

// File: rtl/sdiv_ratio_sel.sv
module sdiv_ratio_sel
   import sdiv_pkg::*;
#(
   parameter int DIV_FAST = 2,
   parameter int DIV_MID  = 3,
   parameter int DIV_SLOW = 4,
   parameter int PW       = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          s_slow,
   input  logic          s_fast,
   input  logic          load,
   output logic [PW-1:0] pin_n,
   output logic [PW-1:0] n_act,
   output logic          cfg_err
);

   rsel_e pin_sel;

   assign pin_sel = decode_sel(s_slow, s_fast);

   always_comb begin
      case (pin_sel)
         RSEL_FAST: pin_n = PW'(DIV_FAST);
         RSEL_SLOW: pin_n = PW'(DIV_SLOW);
         default:   pin_n = PW'(DIV_MID);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         n_act   <= pin_n;
         cfg_err <= 1'b0;
      end else begin
         if (load)
            n_act <= pin_n;
         if (s_slow && s_fast)
            cfg_err <= 1'b1;
      end
   end

endmodule

// File: rtl/sdiv_post.sv
module sdiv_post #(
   parameter int PRE_DIV = 4,
   parameter int PW      = 3,
   parameter int TW      = 5,
   localparam int QW     = $clog2(PRE_DIV)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [QW-1:0] q_cnt,
   input  logic          q_wrap,
   input  logic [PW-1:0] pin_n,
   input  logic [PW-1:0] n_act,
   input  logic          ref_disable,
   output logic          terminal,
   output logic          fb_pulse,
   output logic          ref_out
);

   logic [PW-1:0] p_cnt;
   logic [TW-1:0] t_pos;
   logic [TW-1:0] t_half;
   logic          armed;

   assign terminal = q_wrap && (p_cnt == n_act - PW'(1));
   assign t_pos    = TW'(p_cnt) * TW'(PRE_DIV) + TW'(q_cnt);
   assign t_half   = TW'(n_act) * TW'(PRE_DIV / 2);

   always_ff @(posedge clk) begin
      if (rst) begin
         p_cnt    <= pin_n - PW'(1);
         fb_pulse <= 1'b0;
         armed    <= 1'b0;
         ref_out  <= 1'b0;
      end else begin
         if (terminal)
            p_cnt <= '0;
         else if (q_wrap)
            p_cnt <= p_cnt + PW'(1);
         fb_pulse <= terminal;
         // quiet at once, re-arm only on a period boundary
         if (ref_disable)
            armed <= 1'b0;
         else if (terminal)
            armed <= 1'b1;
         ref_out <= !ref_disable && armed && (t_pos < t_half);
      end
   end

endmodule

// File: rtl/sonet_clk_divider.sv
module sonet_clk_divider #(
   parameter int PRE_DIV  = 4,
   parameter int DIV_FAST = 2,
   parameter int DIV_MID  = 3,
   parameter int DIV_SLOW = 4
) (
   input  logic clk_fast,
   input  logic rst,
   input  logic sel_div16,
   input  logic sel_div8,
   input  logic ref_disable,
   output logic clk_quarter,
   output logic clk_ref_out,
   output logic fb_pulse,
   output logic cfg_err
);

   localparam int PW = $clog2(DIV_SLOW + 1);
   localparam int QW = $clog2(PRE_DIV);
   localparam int TW = $clog2(DIV_SLOW * PRE_DIV) + 1;

   if (PRE_DIV < 2 || (PRE_DIV % 2) != 0) begin : g_bad_pre
      $error("PRE_DIV must be even and at least 2");
   end
   if (DIV_FAST < 2 || DIV_FAST >= DIV_MID || DIV_MID >= DIV_SLOW) begin : g_bad_post
      $error("post ratios must satisfy 2 <= DIV_FAST < DIV_MID < DIV_SLOW");
   end

   logic [QW-1:0] q_cnt;
   logic          q_wrap;
   logic [PW-1:0] pin_n;
   logic [PW-1:0] n_act;
   logic          terminal;

   sdiv_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk     (clk_fast),
      .rst     (rst),
      .q_cnt   (q_cnt),
      .q_wrap  (q_wrap),
      .quarter (clk_quarter)
   );

   sdiv_ratio_sel #(
      .DIV_FAST (DIV_FAST),
      .DIV_MID  (DIV_MID),
      .DIV_SLOW (DIV_SLOW),
      .PW       (PW)
   ) u_sel (
      .clk     (clk_fast),
      .rst     (rst),
      .s_slow  (sel_div16),
      .s_fast  (sel_div8),
      .load    (terminal),
      .pin_n   (pin_n),
      .n_act   (n_act),
      .cfg_err (cfg_err)
   );

   sdiv_post #(.PRE_DIV(PRE_DIV), .PW(PW), .TW(TW)) u_post (
      .clk         (clk_fast),
      .rst         (rst),
      .q_cnt       (q_cnt),
      .q_wrap      (q_wrap),
      .pin_n       (pin_n),
      .n_act       (n_act),
      .ref_disable (ref_disable),
      .terminal    (terminal),
      .fb_pulse    (fb_pulse),
      .ref_out     (clk_ref_out)
   );

endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
   parameter int PRE_DIV = 4
) (
   input logic clk_fast,
   input logic rst,
   input logic sel_div16,
   input logic sel_div8,
   input logic ref_disable,
   input logic clk_quarter,
   input logic clk_ref_out,
   input logic fb_pulse,
   input logic cfg_err
);

   int hi_run;

   always_ff @(posedge clk_fast) begin
      if (rst)
         hi_run <= 0;
      else
         hi_run <= clk_quarter ? hi_run + 1 : 0;
   end

   AST_QUARTER_DUTY: assert property (@(posedge clk_fast) disable iff (rst)
      $fell(clk_quarter) |-> hi_run == PRE_DIV / 2); // R1

   AST_FB_SINGLE: assert property (@(posedge clk_fast) disable iff (rst)
      fb_pulse |=> !fb_pulse); // R6

   AST_REF_RISE_AFTER_FB: assert property (@(posedge clk_fast) disable iff (rst)
      $rose(clk_ref_out) |-> $past(fb_pulse)); // R6

   AST_DISABLE_QUIET: assert property (@(posedge clk_fast) disable iff (rst)
      $past(ref_disable) |-> !clk_ref_out); // R7

   AST_RISE_BEFORE_QUARTER: assert property (@(posedge clk_fast) disable iff (rst)
      $rose(clk_ref_out) |-> !clk_quarter); // R8

   AST_ERR_SET: assert property (@(posedge clk_fast) disable iff (rst)
      (sel_div16 && sel_div8) |=> cfg_err); // R10

   AST_ERR_STICKY: assert property (@(posedge clk_fast) disable iff (rst)
      cfg_err |=> cfg_err); // R10

endmodule

bind sonet_clk_divider sdiv_chk #(.PRE_DIV(PRE_DIV)) u_chk (
   .clk_fast    (clk_fast),
   .rst         (rst),
   .sel_div16   (sel_div16),
   .sel_div8    (sel_div8),
   .ref_disable (ref_disable),
   .clk_quarter (clk_quarter),
   .clk_ref_out (clk_ref_out),
   .fb_pulse    (fb_pulse),
   .cfg_err     (cfg_err)
);

// File: tb/sim_sonet_clk_divider.sv
module sim_sonet_clk_divider;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic s16 = 1'b0;
   logic s8  = 1'b0;
   logic dis = 1'b0;
   logic quarter, ref_o, fb, err;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;

   always #4 clk = ~clk;

   sonet_clk_divider u0 (
      .clk_fast    (clk),
      .rst         (rst),
      .sel_div16   (s16),
      .sel_div8    (s8),
      .ref_disable (dis),
      .clk_quarter (quarter),
      .clk_ref_out (ref_o),
      .fb_pulse    (fb),
      .cfg_err     (err)
   );

   task automatic check_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic sig(input bit use_q);
      return use_q ? quarter : ref_o;
   endfunction

   task automatic wait_rise(input bit use_q);
      logic p;
      p = sig(use_q);
      for (int i = 0; i < 200; i++) begin
         tick();
         if (!p && sig(use_q)) return;
         p = sig(use_q);
      end
   endtask

   task automatic measure(input bit use_q, output int per, output int hi);
      logic p;
      wait_rise(use_q);
      per = 0;
      hi  = 0;
      for (int i = 0; i < 200; i++) begin
         if (sig(use_q)) hi++;
         per++;
         p = sig(use_q);
         tick();
         if (!p && sig(use_q)) break;
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; s16 = 1'b0; s8 = 1'b0; dis = 1'b0;
      repeat (3) tick();
      check_eq("R5 quarter in reset", quarter, 0);
      check_eq("R5 ref in reset", ref_o, 0);
      check_eq("R5 fb in reset", fb, 0);
      check_eq("R5 err in reset", err, 0);
      rst = 1'b0;
      tick();
      check_eq("R5 fb first cycle", fb, 1);
      check_eq("R5 ref first cycle", ref_o, 0);
      tick();
      check_eq("R5 ref second edge", ref_o, 1);
      check_eq("R5 fb second cycle", fb, 0);
   endtask

   task automatic t_quarter();
      int per, hi;
      measure(1'b1, per, hi);
      check_eq("R1 quarter period", per, 4);
      check_eq("R1 quarter high", hi, 2);
   endtask

   task automatic t_ratio(input logic a, input logic b, input int exp, input string req);
      int per, hi;
      s16 = a; s8 = b;
      measure(1'b0, per, hi);
      measure(1'b0, per, hi);
      check_eq({req, " period"}, per, exp);
      check_eq({req, " high"}, hi, exp / 2);
   endtask

   task automatic t_fb();
      int cnt, run, max_run;
      logic p;
      s16 = 1'b0; s8 = 1'b0;
      wait_rise(1'b0);
      wait_rise(1'b0);
      cnt = 0; run = 0; max_run = 0; p = fb;
      for (int i = 0; i < 48; i++) begin
         tick();
         if (fb && !p) cnt++;
         run = fb ? run + 1 : 0;
         if (run > max_run) max_run = run;
         if (!p && ref_o && i > 0) begin
            // R6: this rise must follow a sampled fb cycle
         end
         p = fb;
      end
      check_eq("R6 fb pulses per 48 cycles", cnt, 4);
      check_eq("R6 fb width", max_run, 1);
   endtask

   task automatic t_disable();
      int highs, fbs, per, hi;
      dis = 1'b1;
      tick();
      highs = 0; fbs = 0;
      for (int i = 0; i < 48; i++) begin
         if (ref_o) highs++;
         if (fb) fbs++;
         tick();
      end
      check_eq("R7 ref while disabled", highs, 0);
      check_eq("R7 fb keeps running", fbs, 4);
      dis = 1'b0;
      wait_rise(1'b0);
      check_eq("R8 quarter low at ref rise", quarter, 0);
      tick();
      check_eq("R8 quarter rises next cycle", quarter, 1);
      measure(1'b0, per, hi);
      check_eq("R8 period after enable", per, 12);
   endtask

   task automatic t_switch(input logic a, input logic b, input int old_p, input int new_p,
                           input string req);
      int cnt, per, hi;
      logic p;
      wait_rise(1'b0);
      cnt = 0;
      for (int i = 0; i < 200; i++) begin
         p = ref_o;
         tick();
         cnt++;
         if (cnt == 2) begin
            s16 = a; s8 = b;
         end
         if (!p && ref_o) break;
      end
      check_eq({req, " old period finishes"}, cnt, old_p);
      measure(1'b0, per, hi);
      check_eq({req, " new period"}, per, new_p);
   endtask

   task automatic t_conflict();
      int per, hi;
      rst = 1'b1; s16 = 1'b0; s8 = 1'b0;
      repeat (2) tick();
      rst = 1'b0;
      tick();
      s16 = 1'b1; s8 = 1'b1;
      tick();
      check_eq("R10 err set", err, 1);
      measure(1'b0, per, hi);
      measure(1'b0, per, hi);
      check_eq("R10 priority period", per, 16);
      s16 = 1'b0; s8 = 1'b0;
      repeat (20) tick();
      check_eq("R10 err sticky", err, 1);
      rst = 1'b1;
      tick();
      check_eq("R10 err cleared by reset", err, 0);
      rst = 1'b0;
      repeat (4) tick();
      check_eq("R10 err stays clear", err, 0);
   endtask

   initial begin
      t_reset();
      t_quarter();
      t_ratio(1'b0, 1'b0, 12, "R3");
      t_ratio(1'b1, 1'b0, 16, "R2");
      t_ratio(1'b0, 1'b1, 8, "R4");
      t_fb();
      t_disable();
      s16 = 1'b0; s8 = 1'b0;
      wait_rise(1'b0);
      t_switch(1'b0, 1'b1, 12, 8, "R9 12to8");
      t_switch(1'b1, 1'b0, 8, 16, "R9 8to16");
      t_conflict();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule